// File: doc/BRIEF.md
# Linear Image Sensor Timing Generator

This block turns a free-running master clock into the drive waveforms for a linear CCD or contact image sensor. Each scan line opens with a transfer pulse that moves charge into the shift register. A fixed two-clock guardband follows, and then the block clocks out three groups of pixels in order: dummy, optical black and active. Every pixel period lasts a parameterized number of master clocks. Within each period the block shapes two complementary phase clocks, a reset pulse, and two single-clock strobes that tell a correlated double sampler when to take the reference level and when to take the signal level. After the last active pixel, an end-of-conversion flag is raised for one clock.

Settings come in on plain register inputs: reset-pulse width and position, the two strobe positions, the transfer width, an enable and a polarity bit for each of the four drive outputs, and the dummy and black pixel counts. The block copies all settings once per line, in its load state, and clamps illegal pixel counts to their minimums at that point. The dummy count is written as the real number of dummy pixels plus one.

The sequencer has seven states. LOAD copies the settings. XFER holds the transfer pulse. GUARD is the two-clock gap. DUMMY, BLACK and ACTIVE are the three pixel groups. EOC is the end-of-line clock. The transitions are: LOAD to XFER after one clock, XFER to GUARD when the transfer width has elapsed, GUARD to DUMMY after two clocks, DUMMY to BLACK, BLACK to ACTIVE and ACTIVE to EOC each at the last clock of the group's last pixel, and EOC to LOAD after one clock. Reset enters LOAD.

Top module: `lsg_timing_gen`

## Requirements
- R1: While reset is held, and at the first clock after it is released, `region` is 0, `eoc` is 0, both strobes are 0, and phi1, phi2, rs and tr are all 0. The latched settings reset to all zero, so every output is disabled with polarity 0.
- R2: `region` encodes 0 = transfer/guard/load/end, 1 = dummy, 2 = black, 3 = active. It only ever steps 0→1→2→3→0.
- R3: A line starts with one clock of LOAD. The transfer pulse then lasts (tr_width+1)·PIX_CLKS clocks and is active only while `region` is 0.
- R4: The first pixel of the dummy group starts exactly 2 clocks after the transfer pulse ends. Its phi1 active edge is that start.
- R5: In pixel phase p (0..PIX_CLKS-1), phi1 is active for p < PIX_CLKS/2 and phi2 is active for the rest of the period. Outside pixel groups, both are inactive.
- R6: The reset pulse is active in phases p with rs_pos ≤ p < rs_pos+rs_width+2, so code 0 gives 2 clocks. The pulse is truncated at the end of the pixel and never occurs outside pixel groups.
- R7: `samp_ref` is high for one clock in phase ref_pos of every pixel, and `samp_sig` is high in phase sig_pos.
- R8: The dummy group lasts max(dummy,2)−1 pixels, so values 0 and 1 behave as 2.
- R9: The black group lasts max(black,1) pixels.
- R10: The active group lasts ACTIVE_PIX pixels. Within each group, `pix_count` starts at 0 and advances once per pixel. It is 0 outside pixel groups.
- R11: `eoc` is high for exactly one clock, the clock after the last active pixel. The next line's LOAD follows it.
- R12: Each drive output uses a bit of the enable vector and a bit of the polarity vector, with bit 0 = phi1, bit 1 = phi2, bit 2 = rs, bit 3 = tr. When enabled, the output is the active level XOR the polarity bit. When disabled, the output is held at the polarity bit.
- R13: A change on any setting input takes effect only from the next line. The settings are sampled at the clock that ends LOAD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_rs_width | input | 2 | Reset pulse width code (width = code+2) |
| cfg_rs_pos | input | POS_W | Pixel phase where the reset pulse starts |
| cfg_ref_pos | input | POS_W | Pixel phase of the reference strobe |
| cfg_sig_pos | input | POS_W | Pixel phase of the signal strobe |
| cfg_tr_width | input | 3 | Transfer width code, in pixel periods minus one |
| cfg_out_en | input | 4 | Output enables (phi1, phi2, rs, tr from bit 0) |
| cfg_out_pol | input | 4 | Output polarity bits, same order |
| cfg_dummy | input | 6 | Dummy pixel count plus one |
| cfg_black | input | 6 | Optical black pixel count |
| phi1 | output | 1 | Phase clock 1 |
| phi2 | output | 1 | Phase clock 2 |
| rs | output | 1 | Reset pulse |
| tr | output | 1 | Transfer pulse |
| samp_ref | output | 1 | Reference-level sample strobe |
| samp_sig | output | 1 | Signal-level sample strobe |
| region | output | 2 | Current line region code |
| pix_count | output | CNT_W | Pixel index within the current group |
| eoc | output | 1 | End of conversion, one clock |

## Verification
The bench builds the block with eight master clocks per pixel and four active pixels. With those values a whole line fits in about a hundred clocks, so the bench can compare every output on every clock over more than two lines per setting. It sweeps dummy codes 0 to 4, black codes 0 to 2 and two transfer widths. Every setting case also changes enables, polarities, positions and counts in mid-line. Together these reach the clamps, reset pulses truncated at the pixel end, every phase position and the deferred loading of new settings.

// File: rtl/lsg_pkg.sv
package lsg_pkg;

    typedef enum logic [2:0] {
        ST_LOAD,
        ST_XFER,
        ST_GUARD,
        ST_DUMMY,
        ST_BLACK,
        ST_ACTIVE,
        ST_EOC
    } lsg_state_e;

    typedef enum logic [1:0] {
        RG_IDLE   = 2'd0,
        RG_DUMMY  = 2'd1,
        RG_BLACK  = 2'd2,
        RG_ACTIVE = 2'd3
    } lsg_region_e;

    localparam int GUARD_CYC = 2;
    localparam int DUMMY_MIN = 2;
    localparam int BLACK_MIN = 1;
    localparam int RS_MIN    = 2;

    localparam int NUM_OUT  = 4;
    localparam int OUT_PHI1 = 0;
    localparam int OUT_PHI2 = 1;
    localparam int OUT_RS   = 2;
    localparam int OUT_TR   = 3;

endpackage

// File: rtl/lsg_cfg_latch.sv
// Captures the settings once per line and clamps the pixel counts (R8, R9, R13).
module lsg_cfg_latch #(
    parameter int POS_W = 3,
    parameter int PX_W  = 6,
    parameter int TRW_W = 3,
    parameter int RSW_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [RSW_W-1:0] rs_width_i,
    input  logic [POS_W-1:0] rs_pos_i,
    input  logic [POS_W-1:0] ref_pos_i,
    input  logic [POS_W-1:0] sig_pos_i,
    input  logic [TRW_W-1:0] tr_width_i,
    input  logic [3:0]       en_i,
    input  logic [3:0]       pol_i,
    input  logic [PX_W-1:0]  dummy_i,
    input  logic [PX_W-1:0]  black_i,
    output logic [RSW_W-1:0] rs_width_q,
    output logic [POS_W-1:0] rs_pos_q,
    output logic [POS_W-1:0] ref_pos_q,
    output logic [POS_W-1:0] sig_pos_q,
    output logic [TRW_W-1:0] tr_width_q,
    output logic [3:0]       en_q,
    output logic [3:0]       pol_q,
    output logic [PX_W-1:0]  dummy_q,
    output logic [PX_W-1:0]  black_q
);
    import lsg_pkg::*;

    logic [PX_W-1:0] dummy_cl;
    logic [PX_W-1:0] black_cl;

    always_comb begin
        dummy_cl = (dummy_i < PX_W'(DUMMY_MIN)) ? PX_W'(DUMMY_MIN) : dummy_i;
        black_cl = (black_i < PX_W'(BLACK_MIN)) ? PX_W'(BLACK_MIN) : black_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rs_width_q <= '0;
            rs_pos_q   <= '0;
            ref_pos_q  <= '0;
            sig_pos_q  <= '0;
            tr_width_q <= '0;
            en_q       <= '0;
            pol_q      <= '0;
            dummy_q    <= '0;
            black_q    <= '0;
        end else if (load) begin
            rs_width_q <= rs_width_i;
            rs_pos_q   <= rs_pos_i;
            ref_pos_q  <= ref_pos_i;
            sig_pos_q  <= sig_pos_i;
            tr_width_q <= tr_width_i;
            en_q       <= en_i;
            pol_q      <= pol_i;
            dummy_q    <= dummy_cl;
            black_q    <= black_cl;
        end
    end

endmodule

// File: rtl/lsg_seq.sv
// Line sequencer: LOAD, XFER, GUARD, DUMMY, BLACK, ACTIVE, EOC.
module lsg_seq #(
    parameter int PIX_CLKS   = 8,
    parameter int ACTIVE_PIX = 4,
    parameter int POS_W      = 3,
    parameter int PX_W       = 6,
    parameter int TRW_W      = 3,
    parameter int CNT_W      = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [TRW_W-1:0]     tr_width,
    input  logic [PX_W-1:0]      dummy,
    input  logic [PX_W-1:0]      black,
    output lsg_pkg::lsg_state_e  state,
    output logic [POS_W-1:0]     ph,
    output logic [1:0]           region,
    output logic [CNT_W-1:0]     pix_count,
    output logic                 eoc,
    output logic                 load,
    output logic                 pix_on,
    output logic                 xfer
);
    import lsg_pkg::*;

    localparam int CYC_W = TRW_W + POS_W + 2;

    lsg_state_e       state_nx;
    logic [CYC_W-1:0] cyc;
    logic [CNT_W-1:0] pcnt;
    logic [CYC_W-1:0] tr_last;
    logic             last_ph;
    logic             grp_done;

    always_comb begin
        tr_last = CYC_W'((32'(tr_width) + 32'd1) * 32'(PIX_CLKS) - 32'd1);
        last_ph = (ph == POS_W'(PIX_CLKS - 1));
        grp_done = 1'b0;
        unique case (state)
            ST_DUMMY:  grp_done = last_ph && (pcnt == CNT_W'(dummy - PX_W'(DUMMY_MIN)));
            ST_BLACK:  grp_done = last_ph && (pcnt == CNT_W'(black - PX_W'(1)));
            ST_ACTIVE: grp_done = last_ph && (pcnt == CNT_W'(ACTIVE_PIX - 1));
            default:   grp_done = 1'b0;
        endcase
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_LOAD:   state_nx = ST_XFER;
            ST_XFER:   if (cyc == tr_last) state_nx = ST_GUARD;
            ST_GUARD:  if (cyc == CYC_W'(GUARD_CYC - 1)) state_nx = ST_DUMMY;
            ST_DUMMY:  if (grp_done) state_nx = ST_BLACK;
            ST_BLACK:  if (grp_done) state_nx = ST_ACTIVE;
            ST_ACTIVE: if (grp_done) state_nx = ST_EOC;
            ST_EOC:    state_nx = ST_LOAD;
            default:   state_nx = ST_LOAD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_LOAD;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc  <= '0;
            ph   <= '0;
            pcnt <= '0;
        end else begin
            unique case (state)
                ST_XFER, ST_GUARD: begin
                    cyc  <= (state_nx != state) ? '0 : cyc + CYC_W'(1);
                    ph   <= '0;
                    pcnt <= '0;
                end
                ST_DUMMY, ST_BLACK, ST_ACTIVE: begin
                    ph <= last_ph ? '0 : ph + POS_W'(1);
                    if (last_ph) pcnt <= grp_done ? '0 : pcnt + CNT_W'(1);
                end
                default: begin
                    cyc  <= '0;
                    ph   <= '0;
                    pcnt <= '0;
                end
            endcase
        end
    end

    always_comb begin
        pix_on = (state == ST_DUMMY) || (state == ST_BLACK) || (state == ST_ACTIVE);
        xfer   = (state == ST_XFER);
        load   = (state == ST_LOAD);
        eoc    = (state == ST_EOC);
        unique case (state)
            ST_DUMMY:  region = RG_DUMMY;
            ST_BLACK:  region = RG_BLACK;
            ST_ACTIVE: region = RG_ACTIVE;
            default:   region = RG_IDLE;
        endcase
        pix_count = pix_on ? pcnt : '0;
    end

endmodule

// File: rtl/lsg_wave.sv
// Shapes phase clocks, reset pulse, transfer pulse and sample strobes.
module lsg_wave #(
    parameter int PIX_CLKS = 8,
    parameter int POS_W    = 3,
    parameter int RSW_W    = 2
) (
    input  logic                        pix_on,
    input  logic                        xfer,
    input  logic [POS_W-1:0]            ph,
    input  logic [RSW_W-1:0]            rs_width,
    input  logic [POS_W-1:0]            rs_pos,
    input  logic [POS_W-1:0]            ref_pos,
    input  logic [POS_W-1:0]            sig_pos,
    input  logic [lsg_pkg::NUM_OUT-1:0] en,
    input  logic [lsg_pkg::NUM_OUT-1:0] pol,
    output logic [lsg_pkg::NUM_OUT-1:0] act,
    output logic [lsg_pkg::NUM_OUT-1:0] drv,
    output logic                        samp_ref,
    output logic                        samp_sig
);
    import lsg_pkg::*;

    localparam int RE_W = POS_W + RSW_W + 2;
    localparam int HALF = PIX_CLKS / 2;

    logic [RE_W-1:0] rs_end;
    logic            first_half;

    always_comb begin
        rs_end     = RE_W'(rs_pos) + RE_W'(rs_width) + RE_W'(RS_MIN);
        first_half = (ph < POS_W'(HALF));
        act[OUT_PHI1] = pix_on && first_half;
        act[OUT_PHI2] = pix_on && !first_half;
        act[OUT_RS]   = pix_on && (ph >= rs_pos) && (RE_W'(ph) < rs_end);
        act[OUT_TR]   = xfer;
        samp_ref = pix_on && (ph == ref_pos);
        samp_sig = pix_on && (ph == sig_pos);
    end

    for (genvar gi = 0; gi < NUM_OUT; gi++) begin : g_out
        assign drv[gi] = en[gi] ? (act[gi] ^ pol[gi]) : pol[gi];
    end

endmodule

// File: rtl/lsg_timing_gen.sv
module lsg_timing_gen #(
    parameter int PIX_CLKS   = 8,
    parameter int ACTIVE_PIX = 4,
    parameter int CNT_W      = 8,
    parameter int POS_W      = $clog2(PIX_CLKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cfg_rs_width,
    input  logic [POS_W-1:0] cfg_rs_pos,
    input  logic [POS_W-1:0] cfg_ref_pos,
    input  logic [POS_W-1:0] cfg_sig_pos,
    input  logic [2:0]       cfg_tr_width,
    input  logic [3:0]       cfg_out_en,
    input  logic [3:0]       cfg_out_pol,
    input  logic [5:0]       cfg_dummy,
    input  logic [5:0]       cfg_black,
    output logic             phi1,
    output logic             phi2,
    output logic             rs,
    output logic             tr,
    output logic             samp_ref,
    output logic             samp_sig,
    output logic [1:0]       region,
    output logic [CNT_W-1:0] pix_count,
    output logic             eoc
);
    import lsg_pkg::*;

    localparam int PX_W  = 6;
    localparam int TRW_W = 3;
    localparam int RSW_W = 2;

    logic [RSW_W-1:0]   rs_width_q;
    logic [POS_W-1:0]   rs_pos_q, ref_pos_q, sig_pos_q;
    logic [TRW_W-1:0]   tr_width_q;
    logic [3:0]         en_q, pol_q;
    logic [PX_W-1:0]    dummy_q, black_q;
    lsg_state_e         state;
    logic [POS_W-1:0]   ph;
    logic               load, pix_on, xfer;
    logic [NUM_OUT-1:0] out_act, out_drv;

    lsg_cfg_latch #(.POS_W(POS_W), .PX_W(PX_W), .TRW_W(TRW_W), .RSW_W(RSW_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .load(load),
        .rs_width_i(cfg_rs_width), .rs_pos_i(cfg_rs_pos),
        .ref_pos_i(cfg_ref_pos), .sig_pos_i(cfg_sig_pos),
        .tr_width_i(cfg_tr_width), .en_i(cfg_out_en), .pol_i(cfg_out_pol),
        .dummy_i(cfg_dummy), .black_i(cfg_black),
        .rs_width_q(rs_width_q), .rs_pos_q(rs_pos_q),
        .ref_pos_q(ref_pos_q), .sig_pos_q(sig_pos_q),
        .tr_width_q(tr_width_q), .en_q(en_q), .pol_q(pol_q),
        .dummy_q(dummy_q), .black_q(black_q)
    );

    lsg_seq #(.PIX_CLKS(PIX_CLKS), .ACTIVE_PIX(ACTIVE_PIX), .POS_W(POS_W),
              .PX_W(PX_W), .TRW_W(TRW_W), .CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .tr_width(tr_width_q),
        .dummy(dummy_q), .black(black_q),
        .state(state), .ph(ph), .region(region), .pix_count(pix_count),
        .eoc(eoc), .load(load), .pix_on(pix_on), .xfer(xfer)
    );

    lsg_wave #(.PIX_CLKS(PIX_CLKS), .POS_W(POS_W), .RSW_W(RSW_W)) u_wave (
        .pix_on(pix_on), .xfer(xfer), .ph(ph),
        .rs_width(rs_width_q), .rs_pos(rs_pos_q),
        .ref_pos(ref_pos_q), .sig_pos(sig_pos_q),
        .en(en_q), .pol(pol_q),
        .act(out_act), .drv(out_drv),
        .samp_ref(samp_ref), .samp_sig(samp_sig)
    );

    assign phi1 = out_drv[OUT_PHI1];
    assign phi2 = out_drv[OUT_PHI2];
    assign rs   = out_drv[OUT_RS];
    assign tr   = out_drv[OUT_TR];

endmodule

// File: rtl/lsg_timing_checks.sv
module lsg_timing_checks (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] region,
    input logic       eoc,
    input logic       samp_ref,
    input logic       samp_sig,
    input logic       phi1_act,
    input logic       rs_act,
    input logic       tr_act
);

    p_reset_idle_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (region == 2'd0 && !eoc && !tr_act));

    p_region_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (region != $past(region)) |-> (region == $past(region) + 2'd1));

    p_tr_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tr_act |-> (region == 2'd0));

    p_guard_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phi1_act) |-> (!$past(tr_act) && !$past(tr_act, 2)));

    p_rs_in_pixel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rs_act |-> (region != 2'd0 && !tr_act));

    p_strobe_in_pixel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_ref || samp_sig) |-> (region != 2'd0));

    p_eoc_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        eoc |=> !eoc);

    p_eoc_after_active_r11: assert property (@(posedge clk) disable iff (!rst_n)
        eoc |-> ($past(region) == 2'd3));

endmodule

bind lsg_timing_gen lsg_timing_checks u_chk (
    .clk(clk), .rst_n(rst_n), .region(region), .eoc(eoc),
    .samp_ref(samp_ref), .samp_sig(samp_sig),
    .phi1_act(out_act[0]), .rs_act(out_act[2]), .tr_act(out_act[3])
);

// File: tb/lsg_timing_gen_test.sv
module lsg_timing_gen_test;

    localparam int TCLK = 10;
    localparam int PIX  = 8;
    localparam int ACT  = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cfg_rs_width = '0;
    logic [2:0] cfg_rs_pos = '0, cfg_ref_pos = '0, cfg_sig_pos = '0;
    logic [2:0] cfg_tr_width = '0;
    logic [3:0] cfg_out_en = '0, cfg_out_pol = '0;
    logic [5:0] cfg_dummy = '0, cfg_black = '0;
    logic       phi1, phi2, rs, tr, samp_ref, samp_sig, eoc;
    logic [1:0] region;
    logic [7:0] pix_count;

    int vectors = 0;
    int misses  = 0;
    int n = 0;
    int m_rsw = 0, m_rsp = 0, m_ref = 0, m_sig = 0, m_trw = 0;
    int m_en = 0, m_pol = 0, m_d = 0, m_b = 0;

    always #(TCLK/2) clk = ~clk;

    lsg_timing_gen #(.PIX_CLKS(PIX), .ACTIVE_PIX(ACT), .CNT_W(8)) uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_rs_width(cfg_rs_width), .cfg_rs_pos(cfg_rs_pos),
        .cfg_ref_pos(cfg_ref_pos), .cfg_sig_pos(cfg_sig_pos),
        .cfg_tr_width(cfg_tr_width), .cfg_out_en(cfg_out_en),
        .cfg_out_pol(cfg_out_pol), .cfg_dummy(cfg_dummy), .cfg_black(cfg_black),
        .phi1(phi1), .phi2(phi2), .rs(rs), .tr(tr),
        .samp_ref(samp_ref), .samp_sig(samp_sig),
        .region(region), .pix_count(pix_count), .eoc(eoc)
    );

    task automatic cmp(int act, int exp, string what);
        vectors++;
        if (act != exp) begin
            misses++;
            $display("FAIL %s at t=%0t pos=%0d: actual %0d expected %0d", what, $time, n, act, exp);
        end
    endtask

    function automatic int drive(int en, int pol, int bitn, int a);
        int e = (en >> bitn) & 1;
        int p = (pol >> bitn) & 1;
        return (e != 0) ? (a ^ p) : p;
    endfunction

    function automatic int line_len();
        int t = (m_trw + 1) * PIX;
        return 1 + t + 2 + (m_d - 1 + m_b + ACT) * PIX + 1;
    endfunction

    // Expected outputs at line position n from the latched model settings
    task automatic check_now();
        int t = (m_trw + 1) * PIX;
        int off = 1 + t + 2;
        int nd = m_d - 1;
        int endp = off + (nd + m_b + ACT) * PIX;
        int e_reg = 0, e_cnt = 0, ph = 0;
        int a1 = 0, a2 = 0, ars = 0, atr = 0, sref = 0, ssig = 0, e_eoc = 0;
        if (n >= 1 && n <= t) atr = 1;
        if (n >= off && n < endp) begin
            int k = n - off;
            int pix = k / PIX;
            ph = k % PIX;
            if (pix < nd) begin e_reg = 1; e_cnt = pix; end
            else if (pix < nd + m_b) begin e_reg = 2; e_cnt = pix - nd; end
            else begin e_reg = 3; e_cnt = pix - nd - m_b; end
            a1 = (ph < PIX / 2) ? 1 : 0;
            a2 = 1 - a1;
            ars = (ph >= m_rsp && ph < m_rsp + m_rsw + 2) ? 1 : 0;
            sref = (ph == m_ref) ? 1 : 0;
            ssig = (ph == m_sig) ? 1 : 0;
        end
        if (n == endp) e_eoc = 1;
        cmp(int'(region), e_reg, "R2/R8/R9 region");
        cmp(int'(pix_count), e_cnt, "R10 pix_count");
        cmp(int'(eoc), e_eoc, "R11 eoc");
        cmp(int'(tr), drive(m_en, m_pol, 3, atr), "R3/R12/R13 tr");
        cmp(int'(phi1), drive(m_en, m_pol, 0, a1), "R4/R5/R12 phi1");
        cmp(int'(phi2), drive(m_en, m_pol, 1, a2), "R5/R12 phi2");
        cmp(int'(rs), drive(m_en, m_pol, 2, ars), "R6/R12 rs");
        cmp(int'(samp_ref), sref, "R7 samp_ref");
        cmp(int'(samp_sig), ssig, "R7 samp_sig");
    endtask

    task automatic check_reset();
        cmp(int'(region), 0, "R1 region");
        cmp(int'(eoc), 0, "R1 eoc");
        cmp(int'({samp_ref, samp_sig}), 0, "R1 strobes");
        cmp(int'({phi1, phi2, rs, tr}), 0, "R1 drives");
    endtask

    task automatic run_case(int rsw, int rsp, int rf, int sg, int trw, int en, int pol,
                            int d, int b, int cycles, int mid);
        rst_n = 1'b0;
        cfg_rs_width = 2'(rsw); cfg_rs_pos = 3'(rsp); cfg_ref_pos = 3'(rf);
        cfg_sig_pos = 3'(sg); cfg_tr_width = 3'(trw); cfg_out_en = 4'(en);
        cfg_out_pol = 4'(pol); cfg_dummy = 6'(d); cfg_black = 6'(b);
        repeat (2) @(negedge clk);
        check_reset();
        rst_n = 1'b1;
        #1;
        check_reset();
        m_rsw = 0; m_rsp = 0; m_ref = 0; m_sig = 0; m_trw = 0;
        m_en = 0; m_pol = 0; m_d = 2; m_b = 1;
        n = 0;
        for (int i = 0; i < cycles; i++) begin
            if (i == mid) begin
                // R13: mid-line change, must wait for the next LOAD
                cfg_out_en  = cfg_out_en ^ 4'b0101;
                cfg_out_pol = cfg_out_pol ^ 4'b1010;
                cfg_rs_pos  = cfg_rs_pos + 3'd3;
                cfg_dummy   = 6'((d + 1) % 5);
                cfg_black   = 6'((b + 2) % 3);
            end
            check_now();
            if (n == 0) begin
                m_rsw = int'(cfg_rs_width); m_rsp = int'(cfg_rs_pos);
                m_ref = int'(cfg_ref_pos);  m_sig = int'(cfg_sig_pos);
                m_trw = int'(cfg_tr_width); m_en = int'(cfg_out_en);
                m_pol = int'(cfg_out_pol);
                m_d = (int'(cfg_dummy) < 2) ? 2 : int'(cfg_dummy);
                m_b = (int'(cfg_black) < 1) ? 1 : int'(cfg_black);
            end
            n = (n + 1 >= line_len()) ? 0 : n + 1;
            @(negedge clk);
            #1;
        end
    endtask

    initial begin
        #(TCLK * 200000);
        misses++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        // R1: reset holds all outputs idle even with nonzero settings applied
        cfg_out_pol = 4'hF; cfg_out_en = 4'hF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_reset();
        // Typical contact-sensor setting: rs and tr on, phases off
        run_case(0, 0, 2, 6, 0, 4'b1100, 4'b1000, 2, 1, 260, 45);
        // Sweep of pixel counts (R8, R9 clamps), transfer widths, positions, polarities
        for (int d = 0; d <= 4; d++)
            for (int b = 0; b <= 2; b++)
                for (int t = 0; t <= 1; t++)
                    run_case((d + b) % 4, (d * 3 + b) % 8, (b * 5 + d) % 8, (d + 7 + t) % 8,
                             t * 2, (d * 5 + b * 3 + t) % 16, (d * 3 + b + t * 7) % 16,
                             d, b, 260, 37 + d * 5);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule